// File: doc/BRIEF.md
# Cache-Line Store Backup Queue

This block keeps an ordered record of the stores made by an instruction that allocates a cache line without fetching it. Each record holds the store's address and data. If software later invalidates that line, the saved store can be replayed to memory. Otherwise the data would be lost. The cacheability of each store is decided outside the block and arrives as a flag with the append.

Three commands act on the queue:

- An append adds a record at the tail.
- A discard drops every record.
- An invalidate takes a line address and searches from the oldest record for the first record in the same 32-byte line. If it finds one, it issues a single memory write of that record's data to the record's own full address. It removes the record once memory acknowledges the write, and the remaining records close up in order.

An invalidate that finds nothing finishes in two cycles and writes nothing. While an invalidate is in progress, the block reports busy and refuses further discard and invalidate commands. Appends are still accepted while it is busy.

Top module: `line_backup_queue`

## Requirements
- R1: An append with `appendCacheable` low stores nothing; a later invalidate of that line finds no record.
- R2: Accepted appends are stored at the tail in arrival order, up to 8 records. `full` is high exactly when 8 records are held.
- R3: A cacheable append while `full` is high is dropped, and `overflow` pulses high for one cycle, in the cycle after the append.
- R4: A discard accepted while not busy leaves the queue empty. In that same cycle, a simultaneous append is dropped and a simultaneous invalidate is not accepted.
- R5: An invalidate matches a record when address bits [31:5] are equal. Bits [4:0] of both addresses are ignored.
- R6: Of several matching records, only the oldest is written back and removed. The newer matches stay in the queue for later invalidates.
- R7: The write-back drives `memAddr` with the record's full stored address and `memData` with its stored data. `memReq`, `memAddr` and `memData` hold steady until `memAck` is sampled high.
- R8: After a removal, the remaining records keep their relative order. When the tail record is removed, the next append lands directly after the new last record.
- R9: An invalidate with no match raises `invalDone` for one cycle, two cycles after it is accepted, and `memReq` stays low.
- R10: `busy` rises in the cycle after an invalidate is accepted and stays high until the invalidate completes. Discard and invalidate commands that arrive while `busy` is high are ignored.
- R11: On a hit, `invalDone` pulses in the cycle after `memAck` is accepted, and `memReq` drops in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| appendValid | input | 1 | Append strobe |
| appendAddr | input | 32 | Store address to record |
| appendData | input | 32 | Store data to record |
| appendCacheable | input | 1 | Store address is cacheable |
| discardReq | input | 1 | Drop all records |
| invalValid | input | 1 | Invalidate-by-line strobe |
| invalAddr | input | 32 | Line address to search for |
| memReq | output | 1 | Write-back request |
| memAddr | output | 32 | Write-back address |
| memData | output | 32 | Write-back data |
| memAck | input | 1 | Memory accepted the write |
| full | output | 1 | 8 records held |
| overflow | output | 1 | Append dropped because the queue was full |
| busy | output | 1 | Invalidate in progress |
| invalDone | output | 1 | Invalidate finished |

## Verification
The bench places several records in one line, with different offsets, and invalidates that line repeatedly. This exposes two kinds of error. A design that searched from the newest record, or that removed every match at once, would write back in the wrong order or leave nothing for the second invalidate. A design that wrote to the command address instead of the stored address would show the wrong `memAddr` offset.

The bench removes the tail record and then appends again. A design whose tail pointer does not move back would leave a gap, or overwrite a record. The bench also holds the acknowledge back while it fires a discard and an invalidate. A design that accepted them while busy would lose the records behind the one being written.

Filling the queue beyond its depth, and issuing discard together with an append, exposes a design that wraps on overflow or that lets the append survive the discard.

// File: rtl/sbq_pkg.sv
package sbq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_WRITE
  } sbqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;      // store append at tail
    logic clear;     // drop every record
    logic drop;      // remove record at latched hit index
    logic takeLine;  // latch invalidate line address
    logic takeHit;   // latch first-hit index
  } sbqOps_t;

endpackage

// File: rtl/sbq_first_hit.sv
module sbq_first_hit #(
  parameter int N    = 8,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hitVec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest index (oldest record) wins
  always_comb begin
    found = |hitVec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sbq_datapath.sv
module sbq_datapath
  import sbq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int LINE_BITS = 5,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbqOps_t           ops,
  input  logic [ADDR_W-1:0] appendAddr,
  input  logic [DATA_W-1:0] appendData,
  input  logic [ADDR_W-1:0] invalAddr,
  output logic              full,
  output logic              hitFound,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [CNT_W-1:0]  entryCount
);
  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  lineReg;
  logic [IDX_W-1:0]  hitIdx;
  logic [IDX_W-1:0]  firstIdx;
  logic [DEPTH-1:0]  hitVec;
  logic [CNT_W-1:0]  pushSlot;

  // Per-record line comparators
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitVec[g] = (CNT_W'(g) < count) &&
                       (addrQ[g][ADDR_W-1:LINE_BITS] == lineReg);
  end

  sbq_first_hit #(.N(DEPTH), .IW(IDX_W)) u_first (
    .hitVec(hitVec),
    .found (hitFound),
    .idx   (firstIdx)
  );

  assign full       = (count == CNT_W'(DEPTH));
  assign entryCount = count;
  assign memAddr    = addrQ[hitIdx];
  assign memData    = dataQ[hitIdx];
  assign pushSlot   = ops.drop ? (count - CNT_W'(1)) : count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineReg <= '0;
      hitIdx  <= '0;
    end else begin
      if (ops.takeLine) lineReg <= invalAddr[ADDR_W-1:LINE_BITS];
      if (ops.takeHit)  hitIdx  <= firstIdx;
    end
  end

  // Storage: compaction on removal, then tail write (later assignment wins)
  always_ff @(posedge clk) begin
    if (ops.drop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= hitIdx) begin
          addrQ[i] <= addrQ[i+1];
          dataQ[i] <= dataQ[i+1];
        end
      end
    end
    if (ops.push) begin
      addrQ[IDX_W'(pushSlot)] <= appendAddr;
      dataQ[IDX_W'(pushSlot)] <= appendData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ops.clear) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(ops.push) - CNT_W'(ops.drop);
    end
  end
endmodule

// File: rtl/sbq_control.sv
module sbq_control
  import sbq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    appendValid,
  input  logic    appendCacheable,
  input  logic    discardReq,
  input  logic    invalValid,
  input  logic    memAck,
  input  logic    full,
  input  logic    hitFound,
  output sbqOps_t ops,
  output logic    memReq,
  output logic    busy,
  output logic    overflow,
  output logic    invalDone
);
  sbqState_e state, nextState;
  logic idle, discardGo, invalGo, appendWant;

  always_comb begin
    idle       = (state == ST_IDLE);
    discardGo  = discardReq && idle;
    invalGo    = invalValid && idle && !discardReq;
    appendWant = appendValid && appendCacheable && !discardGo;

    ops          = '0;
    ops.push     = appendWant && !full;
    ops.clear    = discardGo;
    ops.takeLine = invalGo;
    ops.takeHit  = (state == ST_SEARCH);
    ops.drop     = (state == ST_WRITE) && memAck;

    nextState = state;
    unique case (state)
      ST_IDLE:   if (invalGo) nextState = ST_SEARCH;
      ST_SEARCH: nextState = hitFound ? ST_WRITE : ST_IDLE;
      ST_WRITE:  if (memAck) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_WRITE);
  assign busy   = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      overflow  <= 1'b0;
      invalDone <= 1'b0;
    end else begin
      state     <= nextState;
      overflow  <= appendWant && full;
      invalDone <= ((state == ST_SEARCH) && !hitFound) ||
                   ((state == ST_WRITE) && memAck);
    end
  end
endmodule

// File: rtl/line_backup_queue.sv
module line_backup_queue
  import sbq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int LINE_BITS = 5,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              appendValid,
  input  logic [ADDR_W-1:0] appendAddr,
  input  logic [DATA_W-1:0] appendData,
  input  logic              appendCacheable,
  input  logic              discardReq,
  input  logic              invalValid,
  input  logic [ADDR_W-1:0] invalAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memAck,
  output logic              full,
  output logic              overflow,
  output logic              busy,
  output logic              invalDone
);
  sbqOps_t          ops;
  logic             hitFound;
  logic [CNT_W-1:0] entryCount;

  sbq_control u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .appendValid    (appendValid),
    .appendCacheable(appendCacheable),
    .discardReq     (discardReq),
    .invalValid     (invalValid),
    .memAck         (memAck),
    .full           (full),
    .hitFound       (hitFound),
    .ops            (ops),
    .memReq         (memReq),
    .busy           (busy),
    .overflow       (overflow),
    .invalDone      (invalDone)
  );

  sbq_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .LINE_BITS(LINE_BITS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ops       (ops),
    .appendAddr(appendAddr),
    .appendData(appendData),
    .invalAddr (invalAddr),
    .full      (full),
    .hitFound  (hitFound),
    .memAddr   (memAddr),
    .memData   (memData),
    .entryCount(entryCount)
  );
endmodule

// File: rtl/sbq_checker.sv
module sbq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              discardReq,
  input logic              invalValid,
  input logic              busy,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              overflow,
  input logic              full,
  input logic              invalDone,
  input logic [CNT_W-1:0]  entryCount
);
  assert_depth_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entryCount <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(full));

  assert_discard_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (discardReq && !busy) |=> (entryCount == '0));

  assert_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memData)));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalDone |-> !busy);

  assert_inval_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (invalValid && !busy && !discardReq) |=> busy);

  assert_ack_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memAck) |=> (invalDone && !memReq));
endmodule

bind line_backup_queue sbq_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_sbq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .discardReq(discardReq),
  .invalValid(invalValid),
  .busy      (busy),
  .memReq    (memReq),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .memData   (memData),
  .overflow  (overflow),
  .full      (full),
  .invalDone (invalDone),
  .entryCount(entryCount)
);

// File: tb/tb_line_backup_queue.sv
`timescale 1ns/1ps
module tb_line_backup_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        appendValid = 1'b0;
  logic [31:0] appendAddr = '0;
  logic [31:0] appendData = '0;
  logic        appendCacheable = 1'b0;
  logic        discardReq = 1'b0;
  logic        invalValid = 1'b0;
  logic [31:0] invalAddr = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memAck = 1'b0;
  logic        full;
  logic        overflow;
  logic        busy;
  logic        invalDone;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  line_backup_queue dut (
    .clk(clk), .rst_n(rst_n),
    .appendValid(appendValid), .appendAddr(appendAddr),
    .appendData(appendData), .appendCacheable(appendCacheable),
    .discardReq(discardReq), .invalValid(invalValid), .invalAddr(invalAddr),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .full(full), .overflow(overflow), .busy(busy), .invalDone(invalDone)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doAppend(input logic [31:0] a, input logic [31:0] d,
                          input bit cache, input bit expOvf, input string tag);
    @(negedge clk);
    appendValid = 1'b1; appendAddr = a; appendData = d; appendCacheable = cache;
    @(negedge clk);
    appendValid = 1'b0; appendCacheable = 1'b0;
    check(overflow == expOvf, tag, 32'(overflow), 32'(expOvf));
  endtask

  // Invalidate; on a hit, ack after ackDelay cycles, optionally firing
  // discard+invalidate while the write is pending.
  task automatic doInval(input logic [31:0] a, input bit expHit,
                         input logic [31:0] expAddr, input logic [31:0] expData,
                         input int ackDelay, input bit disturb, input string tag);
    @(negedge clk);
    invalValid = 1'b1; invalAddr = a;
    @(negedge clk);
    invalValid = 1'b0;
    check(busy == 1'b1, {tag, " busy after accept (R10)"}, 32'(busy), 32'd1);
    @(negedge clk);
    if (expHit) begin
      check(memReq == 1'b1, {tag, " memReq"}, 32'(memReq), 32'd1);
      check(memAddr == expAddr, {tag, " memAddr"}, memAddr, expAddr);
      check(memData == expData, {tag, " memData"}, memData, expData);
      for (int k = 0; k < ackDelay; k++) begin
        if (disturb && k == 0) begin
          discardReq = 1'b1; invalValid = 1'b1;
        end else begin
          discardReq = 1'b0; invalValid = 1'b0;
        end
        @(negedge clk);
        check(memReq && memAddr == expAddr && memData == expData,
              {tag, " held until ack (R7)"}, memAddr, expAddr);
      end
      discardReq = 1'b0; invalValid = 1'b0;
      memAck = 1'b1;
      @(negedge clk);
      memAck = 1'b0;
      check(invalDone == 1'b1, {tag, " done after ack (R11)"}, 32'(invalDone), 32'd1);
      check(memReq == 1'b0, {tag, " memReq dropped (R11)"}, 32'(memReq), 32'd0);
    end else begin
      check(memReq == 1'b0, {tag, " no write on miss (R9)"}, 32'(memReq), 32'd0);
      check(invalDone == 1'b1, {tag, " done on miss (R9)"}, 32'(invalDone), 32'd1);
    end
    check(busy == 1'b0, {tag, " idle after done (R10)"}, 32'(busy), 32'd0);
  endtask

  task automatic doDiscard();
    @(negedge clk);
    discardReq = 1'b1;
    @(negedge clk);
    discardReq = 1'b0;
  endtask

  task automatic testReset();
    check(!full && !busy && !memReq && !overflow && !invalDone, "reset outputs",
          {27'd0, full, busy, memReq, overflow, invalDone}, 32'd0);
  endtask

  task automatic testNonCacheable();
    doAppend(32'h4000_0008, 32'hAAAA_0001, 1'b0, 1'b0, "R1 append");
    doInval(32'h4000_0000, 1'b0, 0, 0, 0, 1'b0, "R1 non-cacheable ignored");
  endtask

  task automatic testOrderAndMatch();
    doAppend(32'h1000_0004, 32'hD000_0001, 1'b1, 1'b0, "R2 a0");
    doAppend(32'h2000_0040, 32'hD000_0002, 1'b1, 1'b0, "R2 a1");
    doAppend(32'h1000_001C, 32'hD000_0003, 1'b1, 1'b0, "R2 a2");
    // low bits of command differ from stored: R5; stored address used: R7
    doInval(32'h1000_0010, 1'b1, 32'h1000_0004, 32'hD000_0001, 0, 1'b0, "R5 R6 oldest");
    doInval(32'h1000_0000, 1'b1, 32'h1000_001C, 32'hD000_0003, 0, 1'b0, "R6 later match kept");
    doInval(32'h1000_001F, 1'b0, 0, 0, 0, 1'b0, "R6 line exhausted");
    doInval(32'h2000_005F, 1'b1, 32'h2000_0040, 32'hD000_0002, 0, 1'b0, "R8 middle kept");
    doInval(32'h2000_0040, 1'b0, 0, 0, 0, 1'b0, "R9 empty miss");
  endtask

  task automatic testTailRemoval();
    doAppend(32'h3000_0000, 32'hB000_0001, 1'b1, 1'b0, "R8 a");
    doAppend(32'h3000_0004, 32'hB000_0002, 1'b1, 1'b0, "R8 b");
    doAppend(32'h5000_0000, 32'hB000_0003, 1'b1, 1'b0, "R8 c");
    doInval(32'h5000_0000, 1'b1, 32'h5000_0000, 32'hB000_0003, 0, 1'b0, "R8 tail removed");
    doAppend(32'h3000_0008, 32'hB000_0004, 1'b1, 1'b0, "R8 d");
    doInval(32'h3000_0000, 1'b1, 32'h3000_0000, 32'hB000_0001, 0, 1'b0, "R8 order 1");
    doInval(32'h3000_0000, 1'b1, 32'h3000_0004, 32'hB000_0002, 0, 1'b0, "R8 order 2");
    doInval(32'h3000_0000, 1'b1, 32'h3000_0008, 32'hB000_0004, 0, 1'b0, "R8 order 3");
    doInval(32'h3000_0000, 1'b0, 0, 0, 0, 1'b0, "R8 drained");
  endtask

  task automatic testFullOverflow();
    for (int i = 0; i < 8; i++)
      doAppend(32'h6000_0000 + 32'(i) * 32'h20, 32'hC000_0000 + 32'(i), 1'b1, 1'b0, "R2 fill");
    check(full == 1'b1, "R2 full at 8", 32'(full), 32'd1);
    doAppend(32'h7000_0000, 32'hC000_00FF, 1'b1, 1'b1, "R3 overflow pulse");
    @(negedge clk);
    check(overflow == 1'b0, "R3 overflow one cycle", 32'(overflow), 32'd0);
    doInval(32'h7000_0000, 1'b0, 0, 0, 0, 1'b0, "R3 dropped append absent");
    doInval(32'h6000_00E0, 1'b1, 32'h6000_00E0, 32'hC000_0007, 0, 1'b0, "R2 tail record");
    check(full == 1'b0, "R2 not full at 7", 32'(full), 32'd0);
    doDiscard();
    doInval(32'h6000_0000, 1'b0, 0, 0, 0, 1'b0, "R4 discard empties");
  endtask

  task automatic testBusyIgnore();
    doAppend(32'h8000_0000, 32'hE000_0011, 1'b1, 1'b0, "R10 x1");
    doAppend(32'h8000_0010, 32'hE000_0022, 1'b1, 1'b0, "R10 x2");
    doInval(32'h8000_0000, 1'b1, 32'h8000_0000, 32'hE000_0011, 3, 1'b1, "R7 R10 held");
    @(negedge clk);
    check(busy == 1'b0 && invalDone == 1'b0, "R10 ignored inval no effect",
          {30'd0, busy, invalDone}, 32'd0);
    doInval(32'h8000_0000, 1'b1, 32'h8000_0010, 32'hE000_0022, 0, 1'b0, "R10 discard ignored");
  endtask

  task automatic testDiscardPriority();
    doAppend(32'h9000_0000, 32'hF000_0001, 1'b1, 1'b0, "R4 pre");
    @(negedge clk);
    discardReq = 1'b1; appendValid = 1'b1; appendCacheable = 1'b1;
    appendAddr = 32'h9000_0004; appendData = 32'hF000_0002;
    invalValid = 1'b1; invalAddr = 32'h9000_0000;
    @(negedge clk);
    discardReq = 1'b0; appendValid = 1'b0; appendCacheable = 1'b0; invalValid = 1'b0;
    check(busy == 1'b0, "R4 inval not accepted with discard", 32'(busy), 32'd0);
    @(negedge clk);
    check(invalDone == 1'b0, "R4 no done with discard", 32'(invalDone), 32'd0);
    doInval(32'h9000_0000, 1'b0, 0, 0, 0, 1'b0, "R4 append lost to discard");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testNonCacheable();
    testOrderAndMatch();
    testTailRemoval();
    testFullOverflow();
    testBusyIgnore();
    testDiscardPriority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule